// File: doc/BRIEF.md
# Self-Identifying Host Register Bank

This block holds the host-visible control and status words of a network controller. The host reaches them through a byte-offset address bus, with separate read and write strobes. Every word is 16 bits. The low six bits of each word are a fixed code that names the register. Bit 0 of that code tells the host what kind of register it is: 1 for a configuration register and 0 for a status register. The upper ten bits carry the register's contents. A host driver can therefore check the code field of any word it reads and confirm which register the value came from.

Configuration registers take odd codes. The host can read and write them, and their contents drive the controller core. Status registers take even codes. They are read-only and show live hardware inputs, including an interrupt-status-queue location that the host reads first when it services an interrupt. The transmit command has two offsets: a write-only offset where commands are issued, and a read-only offset that shows the last command issued. Three 10-bit event counters (missed receive frames, transmit collisions, cable reflectometry) count pulses from the core. They saturate at their maximum and clear when the host reads them.

Top module: `sreg_bank`

## Requirements
- R1: A read of a mapped location returns the register's fixed 6-bit code in bits [5:0] and its contents in bits [15:6]. A write can never change bits [5:0]. Bit 0 of the code is 1 for every configuration register.
- R2: The configuration registers are at offsets 0x102 (code 0x03), 0x104 (code 0x05), 0x106 (code 0x07) and 0x10A (code 0x0B). A write stores wr_data_i[15:6] at the clock edge. The stored value then reads back and appears on cfg_bits_o, with slot 0 at 0x102, slot 1 at 0x104, slot 2 at 0x106 and slot 3 at 0x10A, each slot 10 bits wide in ascending order.
- R3: The status registers are at offsets 0x124 (code 0x04, shows rx_stat_i), 0x128 (code 0x08, shows tx_stat_i) and the interrupt status queue at 0x120 (code 0x22, shows isq_stat_i). Writes to these offsets have no effect.
- R4: A write at offset 0x144 stores wr_data_i[15:6] as the transmit command. From the next cycle the command appears on tx_cmd_o and at the read-only offset 0x108 (code 0x09). Writes at 0x108 are ignored. Reads at 0x144 return zero.
- R5: The counters are at 0x130 (code 0x10, counts pulses on cnt_inc_i[0]), 0x132 (code 0x18, counts cnt_inc_i[1]) and 0x134 (code 0x1C, counts cnt_inc_i[2]). Each cycle in which the increment is high adds one at the clock edge. The count occupies bits [15:6], and host writes to a counter have no effect.
- R6: A counter that has reached 1023 stays at 1023 while further increments arrive.
- R7: A read of a counter returns its current value and clears it at the same clock edge. An increment that arrives in that same cycle is dropped.
- R8: Reset clears every configuration register, the transmit command and every counter to zero.
- R9: Unmapped offsets read as zero, and writes to them change no register.
- R10: Address bit 0 is ignored, so an odd offset reaches the same register as the even offset just below it.
- R11: When rd_en_i is low, rd_data_o is zero and no counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 9 | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write word; only bits [15:6] are used |
| rd_en_i | input | 1 | Read strobe; also the clear-on-read trigger |
| rd_data_o | output | 16 | Read word (combinational from address and state) |
| rx_stat_i | input | 10 | Live receive status bits |
| tx_stat_i | input | 10 | Live transmit status bits |
| isq_stat_i | input | 10 | Word presented by the interrupt queue logic |
| cnt_inc_i | input | 3 | Increment pulses for the three counters |
| cfg_bits_o | output | 40 | Contents of the four configuration registers |
| tx_cmd_o | output | 10 | Last issued transmit command |

## Verification
The bench targets the edges of the address map. Both transmit command offsets are exercised. A bank that decoded them as one read/write register would let a write at 0x108 through, or would echo the command back at 0x144. Odd-offset writes are included because a decoder that used address bit 0 would miss every register. Writes to status and unmapped offsets are followed by readback of the nearby registers, which catches a decoder that aliases them.

A counter is held at its maximum while further increments arrive, so a wrapping counter reads back as a small number. The bench then reads a counter in the same cycle as an increment. A bank that gave the increment priority would read back one on the next access instead of zero. Finally, the counter offset is addressed with the read strobe low, and the counter must survive. This catches a clear that follows the address alone rather than the strobe.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int CODE_W = 6;
   localparam int N_CFG  = 4;
   localparam int N_CNT  = 3;

   typedef logic [15:0]       ofs_t;
   typedef logic [CODE_W-1:0] code_t;

   // configuration slots: odd codes
   localparam ofs_t  CFG_OFS  [N_CFG] = '{16'h0102, 16'h0104, 16'h0106, 16'h010A};
   localparam code_t CFG_CODE [N_CFG] = '{6'h03, 6'h05, 6'h07, 6'h0B};

   // event counters: even codes
   localparam ofs_t  CNT_OFS  [N_CNT] = '{16'h0130, 16'h0132, 16'h0134};
   localparam code_t CNT_CODE [N_CNT] = '{6'h10, 6'h18, 6'h1C};

   // transmit command: view and issue port
   localparam ofs_t  TXV_OFS  = 16'h0108;
   localparam code_t TXV_CODE = 6'h09;
   localparam ofs_t  TXP_OFS  = 16'h0144;

   // live status words
   localparam ofs_t  ISQ_OFS  = 16'h0120;
   localparam code_t ISQ_CODE = 6'h22;
   localparam ofs_t  RXS_OFS  = 16'h0124;
   localparam code_t RXS_CODE = 6'h04;
   localparam ofs_t  TXS_OFS  = 16'h0128;
   localparam code_t TXS_CODE = 6'h08;
endpackage

// File: rtl/sreg_cfg_reg.sv
module sreg_cfg_reg #(
   parameter int FLD_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [FLD_W-1:0] d,
   output logic [FLD_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/sreg_evt_cnt.sv
module sreg_evt_cnt #(
   parameter int FLD_W  = 10,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [FLD_W-1:0] q
);
   localparam logic [FLD_W-1:0] CNT_MAX = '1;

   logic             step;
   logic [FLD_W-1:0] nxt;

   generate
      if (SAT_EN) begin : g_sat
         assign step = inc && (q != CNT_MAX);
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   assign nxt = q + FLD_W'(1);

   // host clear outranks a hardware increment in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (step) q <= nxt;
   end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int FLD_W  = 10,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    wr_en_i,
   input  logic [FLD_W+6-1:0]      wr_data_i,
   input  logic                    rd_en_i,
   output logic [FLD_W+6-1:0]      rd_data_o,
   input  logic [FLD_W-1:0]        rx_stat_i,
   input  logic [FLD_W-1:0]        tx_stat_i,
   input  logic [FLD_W-1:0]        isq_stat_i,
   input  logic [2:0]              cnt_inc_i,
   output logic [4*FLD_W-1:0]      cfg_bits_o,
   output logic [FLD_W-1:0]        tx_cmd_o
);
   localparam int DATA_W  = FLD_W + CODE_W;
   localparam int WADDR_W = ADDR_W - 1;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("sreg_bank: ADDR_W must lie in 9..16");
      end
      if (FLD_W < 1) begin : g_bad_fld
         $error("sreg_bank: FLD_W must be positive");
      end
   endgenerate

   logic [WADDR_W-1:0] waddr;
   logic [FLD_W-1:0]   wfld;
   logic               unused_bits;

   assign waddr       = addr_i[ADDR_W-1:1];
   assign wfld        = wr_data_i[DATA_W-1:CODE_W];
   assign unused_bits = ^{addr_i[0], wr_data_i[CODE_W-1:0]};

   logic               txv_hit, txp_hit, isq_hit, rxs_hit, txs_hit;
   logic [N_CFG-1:0]   cfg_hit;
   logic [N_CNT-1:0]   cnt_hit;
   logic [FLD_W-1:0]   cfg_q [N_CFG];
   logic [FLD_W-1:0]   cnt_q [N_CNT];
   logic [N_CNT*FLD_W-1:0] cnt_flat;

   assign txv_hit = (waddr == TXV_OFS[ADDR_W-1:1]);
   assign txp_hit = (waddr == TXP_OFS[ADDR_W-1:1]);
   assign isq_hit = (waddr == ISQ_OFS[ADDR_W-1:1]);
   assign rxs_hit = (waddr == RXS_OFS[ADDR_W-1:1]);
   assign txs_hit = (waddr == TXS_OFS[ADDR_W-1:1]);

   genvar gi;
   generate
      for (gi = 0; gi < N_CFG; gi++) begin : g_cfg
         assign cfg_hit[gi] = (waddr == CFG_OFS[gi][ADDR_W-1:1]);
         sreg_cfg_reg #(.FLD_W(FLD_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en_i && cfg_hit[gi]),
            .d     (wfld),
            .q     (cfg_q[gi])
         );
         assign cfg_bits_o[gi*FLD_W +: FLD_W] = cfg_q[gi];
      end

      for (gi = 0; gi < N_CNT; gi++) begin : g_cnt
         assign cnt_hit[gi] = (waddr == CNT_OFS[gi][ADDR_W-1:1]);
         sreg_evt_cnt #(.FLD_W(FLD_W), .SAT_EN(SAT_EN)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc_i[gi]),
            .clr   (rd_en_i && cnt_hit[gi]),
            .q     (cnt_q[gi])
         );
         assign cnt_flat[gi*FLD_W +: FLD_W] = cnt_q[gi];
      end
   endgenerate

   // issue port writes; the view offset has no write path
   sreg_cfg_reg #(.FLD_W(FLD_W)) u_txcmd (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en_i && txp_hit),
      .d     (wfld),
      .q     (tx_cmd_o)
   );

   // read word: contents above, fixed code below
   always_comb begin
      rd_data_o = '0;
      if (rd_en_i) begin
         for (int i = 0; i < N_CFG; i++)
            if (cfg_hit[i]) rd_data_o = {cfg_q[i], CFG_CODE[i]};
         for (int i = 0; i < N_CNT; i++)
            if (cnt_hit[i]) rd_data_o = {cnt_q[i], CNT_CODE[i]};
         if (txv_hit) rd_data_o = {tx_cmd_o,   TXV_CODE};
         if (isq_hit) rd_data_o = {isq_stat_i, ISQ_CODE};
         if (rxs_hit) rd_data_o = {rx_stat_i,  RXS_CODE};
         if (txs_hit) rd_data_o = {tx_stat_i,  TXS_CODE};
      end
   end
endmodule

// File: rtl/sreg_bank_chk.sv
module sreg_bank_chk
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int FLD_W  = 10,
   parameter bit SAT_EN = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       addr_i,
   input logic                    wr_en_i,
   input logic [FLD_W+6-1:0]      wr_data_i,
   input logic                    rd_en_i,
   input logic [FLD_W+6-1:0]      rd_data_o,
   input logic [2:0]              cnt_inc_i,
   input logic [4*FLD_W-1:0]      cfg_bits_o,
   input logic [FLD_W-1:0]        tx_cmd_o,
   input logic [N_CNT*FLD_W-1:0]  cnt_flat
);
   localparam int DATA_W = FLD_W + CODE_W;
   localparam logic [FLD_W-1:0] CNT_MAX = '1;

   logic [ADDR_W-2:0] wa;
   logic              cfg_any;
   assign wa = addr_i[ADDR_W-1:1];
   always_comb begin
      cfg_any = 1'b0;
      for (int i = 0; i < N_CFG; i++)
         if (wa == CFG_OFS[i][ADDR_W-1:1]) cfg_any = 1'b1;
   end

   // R4
   txcmd_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wa == TXP_OFS[ADDR_W-1:1]) |=> (tx_cmd_o == $past(wr_data_i[DATA_W-1:CODE_W])));

   // R4
   txview_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && wa == TXV_OFS[ADDR_W-1:1]) |-> (rd_data_o == {tx_cmd_o, TXV_CODE}));

   // R11
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> (rd_data_o == '0));

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ($stable(cfg_bits_o) && $stable(tx_cmd_o)));

   // R1
   type_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && cfg_any) |-> rd_data_o[0]);

   genvar gi;
   generate
      for (gi = 0; gi < N_CNT; gi++) begin : g_cc
         // R7
         cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en_i && wa == CNT_OFS[gi][ADDR_W-1:1]) |=> (cnt_flat[gi*FLD_W +: FLD_W] == '0));
         if (SAT_EN) begin : g_sat
            // R6
            cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (cnt_flat[gi*FLD_W +: FLD_W] == CNT_MAX && cnt_inc_i[gi]
                && !(rd_en_i && wa == CNT_OFS[gi][ADDR_W-1:1]))
               |=> (cnt_flat[gi*FLD_W +: FLD_W] == CNT_MAX));
         end
      end
   endgenerate
endmodule

bind sreg_bank sreg_bank_chk #(.ADDR_W(ADDR_W), .FLD_W(FLD_W), .SAT_EN(SAT_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_i     (addr_i),
   .wr_en_i    (wr_en_i),
   .wr_data_i  (wr_data_i),
   .rd_en_i    (rd_en_i),
   .rd_data_o  (rd_data_o),
   .cnt_inc_i  (cnt_inc_i),
   .cfg_bits_o (cfg_bits_o),
   .tx_cmd_o   (tx_cmd_o),
   .cnt_flat   (cnt_flat)
);

// File: tb/sreg_bank_tb.sv
`timescale 1ns/1ps
module sreg_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  addr_i = '0;
   logic        wr_en_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic        rd_en_i = 1'b0;
   logic [15:0] rd_data_o;
   logic [9:0]  rx_stat_i = 10'h155;
   logic [9:0]  tx_stat_i = 10'h2AA;
   logic [9:0]  isq_stat_i = 10'h0F0;
   logic [2:0]  cnt_inc_i = '0;
   logic [39:0] cfg_bits_o;
   logic [9:0]  tx_cmd_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sreg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
      .rx_stat_i(rx_stat_i), .tx_stat_i(tx_stat_i), .isq_stat_i(isq_stat_i),
      .cnt_inc_i(cnt_inc_i), .cfg_bits_o(cfg_bits_o), .tx_cmd_o(tx_cmd_o)
   );

   // {op(0 write,1 read), req number, offset, write data, expected read}
   typedef logic [57:0] vec_t;
   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      {2'd0, 8'd2,  16'h0102, 16'hFFFF, 16'h0000},  // R2
      {2'd1, 8'd2,  16'h0102, 16'h0000, 16'hFFC3},  // R2 R1
      {2'd0, 8'd2,  16'h0104, 16'h1234, 16'h0000},
      {2'd1, 8'd1,  16'h0104, 16'h0000, 16'h1205},  // R1 code kept
      {2'd0, 8'd2,  16'h0106, 16'hABCD, 16'h0000},
      {2'd1, 8'd2,  16'h0106, 16'h0000, 16'hABC7},
      {2'd0, 8'd10, 16'h010B, 16'h5555, 16'h0000},  // R10
      {2'd1, 8'd10, 16'h010A, 16'h0000, 16'h554B},
      {2'd1, 8'd10, 16'h010B, 16'h0000, 16'h554B},
      {2'd0, 8'd4,  16'h0108, 16'hFFFF, 16'h0000},  // R4 view ignores write
      {2'd1, 8'd4,  16'h0108, 16'h0000, 16'h0009},
      {2'd0, 8'd4,  16'h0144, 16'h8040, 16'h0000},
      {2'd1, 8'd4,  16'h0108, 16'h0000, 16'h8049},
      {2'd1, 8'd4,  16'h0144, 16'h0000, 16'h0000},
      {2'd0, 8'd3,  16'h0124, 16'hFFFF, 16'h0000},  // R3
      {2'd1, 8'd3,  16'h0124, 16'h0000, 16'h5544},
      {2'd1, 8'd3,  16'h0128, 16'h0000, 16'hAA88},
      {2'd1, 8'd3,  16'h0120, 16'h0000, 16'h3C22},
      {2'd0, 8'd9,  16'h0000, 16'hFFFF, 16'h0000},  // R9
      {2'd1, 8'd9,  16'h0000, 16'h0000, 16'h0000},
      {2'd1, 8'd9,  16'h0100, 16'h0000, 16'h0000},
      {2'd1, 8'd9,  16'h0102, 16'h0000, 16'hFFC3}
   };

   task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] ofs, input logic [15:0] d);
      @(negedge clk);
      addr_i = ofs[8:0]; wr_data_i = d; wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input int req, input logic [15:0] ofs, input logic [15:0] exp);
      @(negedge clk);
      addr_i = ofs[8:0]; rd_en_i = 1'b1;
      #1 check(req, 64'(rd_data_o), 64'(exp));
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic pulse(input int idx, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cnt_inc_i[idx] = 1'b1;
      end
      @(negedge clk);
      cnt_inc_i[idx] = 1'b0;
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state
      #1 check(8, 64'(cfg_bits_o), 64'h0);
      check(8, 64'(tx_cmd_o), 64'h0);
      rd(8, 16'h0102, 16'h0003);
      rd(8, 16'h0130, 16'h0010);
      // R11 strobe low gives zero
      @(negedge clk); addr_i = 9'h102; #1 check(11, 64'(rd_data_o), 64'h0);

      for (int k = 0; k < NV; k++) begin
         if (VEC[k][57:56] == 2'd0) wr(VEC[k][47:32], VEC[k][31:16]);
         else rd(int'(VEC[k][55:48]), VEC[k][47:32], VEC[k][15:0]);
      end
      // R2 config outputs, R4 command output
      @(negedge clk);
      check(2, 64'(cfg_bits_o), 64'({10'h155, 10'h2AF, 10'h048, 10'h3FF}));
      check(4, 64'(tx_cmd_o), 64'h201);

      // R5 counting and ignored write
      pulse(0, 5);
      wr(16'h0130, 16'hFFFF);
      rd(5, 16'h0130, 16'h0150);
      rd(7, 16'h0130, 16'h0010);

      // R11 no clear without strobe
      pulse(0, 2);
      @(negedge clk); addr_i = 9'h130; rd_en_i = 1'b0;
      @(negedge clk);
      rd(11, 16'h0130, 16'h0090);

      // R6 saturation
      pulse(1, 1100);
      rd(6, 16'h0132, 16'hFFD8);

      // R7 read in same cycle as increment drops it
      pulse(2, 3);
      @(negedge clk);
      addr_i = 9'h134; rd_en_i = 1'b1; cnt_inc_i[2] = 1'b1;
      #1 check(7, 64'(rd_data_o), 64'h00DC);
      @(negedge clk);
      rd_en_i = 1'b0; cnt_inc_i[2] = 1'b0;
      rd(7, 16'h0134, 16'h001C);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule